// File: doc/BRIEF.md
# Page-Tagged Trust and Critical Tag Store

This block keeps two tag bits, trusted and critical, for every 32-bit word of a small set of resident 4 KB memory pages. A fully associative array of page numbers picks one of sixteen slots. The slot number, joined with the upper bits of the word offset, addresses a bitmask RAM with one read side and one write side. An integrity checker running beside a processor pipeline uses the read side to ask whether the instruction at a program counter is trusted, or whether a data word is trusted or critical. A word whose page is not resident reads as neither, and the response flags a miss.

The write side serves two clients. The first is initialization commands. The host pipeline treats these command instructions as no-ops and forwards them with the identifier of the module they address. One command kind loads a slot with a page number and a valid bit. The other kind writes a whole 32-bit bitmask row of a slot. The second client is checker writebacks, which update the two tags of a single word when that word is stored to memory.

Top module: `page_tag_store`

## Requirements
- R1: After reset no slot is valid, so every lookup reports a miss until a page command for this module has been accepted.
- R2: A lookup presented with lookValid in one cycle is answered in the next cycle with respValid high. In any cycle without a response, respValid, respTrusted, respCritical and respMiss are all low.
- R3: An address splits into page number addr[31:12] and word offset w = addr[11:2]. addr[1:0] is ignored. Bitmap row r of a slot covers words 16r to 16r+15. Word w keeps its trusted bit at bit 2*(w mod 16) of row w/16 and its critical bit one position above.
- R4: A lookup whose page matches no valid slot returns respMiss=1, respTrusted=0 and respCritical=0.
- R5: A page command (cmdOp=0) sets the page number and valid bit of slot cmdSlot. A valid bit of 0 removes the page. A lookup presented in the same cycle as the command still sees the old slot contents. Lookups from the following cycle see the new contents.
- R6: A mask command (cmdOp=1) replaces row cmdRow of slot cmdSlot with cmdData. Each slot has its own 64 rows.
- R7: A command whose cmdTarget differs from the module identifier (default 5) changes no slot and no bitmap row.
- R8: A writeback to a resident page changes only the two tag bits of the addressed word. A writeback to a page that is not resident changes nothing.
- R9: When a command for this module and a writeback arrive in the same cycle, the command is applied and the writeback is dropped.
- R10: When a lookup reads a word in the same cycle that a writeback or a mask command writes it, the response carries the newly written bits.
- R11: When two valid slots hold the same page number, the lower-numbered slot answers the lookup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command instruction present |
| cmdTarget | input | 4 | Identifier of the module the command addresses |
| cmdOp | input | 1 | 0 = load slot page entry, 1 = write bitmask row |
| cmdSlot | input | 4 | Slot the command acts on |
| cmdPage | input | 20 | Page number for a page command |
| cmdEntryValid | input | 1 | Valid bit for a page command |
| cmdRow | input | 6 | Bitmask row for a mask command |
| cmdData | input | 32 | Bitmask row contents for a mask command |
| wbValid | input | 1 | Checker tag writeback present |
| wbAddr | input | 32 | Byte address of the written word |
| wbTrusted | input | 1 | New trusted bit |
| wbCritical | input | 1 | New critical bit |
| lookValid | input | 1 | Lookup request present |
| lookAddr | input | 32 | Instruction or data byte address to look up |
| respValid | output | 1 | Lookup response present |
| respTrusted | output | 1 | Word is trusted |
| respCritical | output | 1 | Word is critical |
| respMiss | output | 1 | Page is not resident |

## Verification
A corrupted page entry or valid bit shows up as a wrong hit or miss for every word of one page. It appears on the first response after the bad write, one cycle after the lookup is presented. A corrupted bitmap bit affects only one word, and only a lookup of that exact word exposes it. For that reason the sweeps read every word of every resident page, both before and after the writebacks and slot changes. Errors in the write path are narrow: a wrong mask, a wrong lane or a wrong write priority flips a neighbouring tag. So the bench reads back whole rows around every write and compares them against its own bitmap model.

// File: rtl/page_tag_pkg.sv
package page_tag_pkg;

  typedef enum logic {
    OP_PAGE = 1'b0,
    OP_MASK = 1'b1
  } tagOpE;

  // Strobes from control to datapath
  typedef struct packed {
    logic camWr;
    logic ramWr;
    logic ramFromCmd;
  } tagStrobeT;

endpackage

// File: rtl/tag_cam.sv
module tag_cam #(
  parameter int SLOTS      = 16,
  parameter int PAGE_NUM_W = 20,
  parameter int PORTS      = 2,
  parameter int SLOT_W     = $clog2(SLOTS)
) (
  input  logic                                clk,
  input  logic                                rstN,
  input  logic                                wrEn,
  input  logic [SLOT_W-1:0]                   wrSlot,
  input  logic [PAGE_NUM_W-1:0]               wrPage,
  input  logic                                wrValid,
  input  logic [PORTS-1:0][PAGE_NUM_W-1:0]    srchPage,
  output logic [PORTS-1:0]                    srchHit,
  output logic [PORTS-1:0][SLOT_W-1:0]        srchSlot
);

  logic [PAGE_NUM_W-1:0] pageQ [SLOTS];
  logic [SLOTS-1:0]      validQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validQ <= '0;
    end else if (wrEn) begin
      validQ[wrSlot] <= wrValid;
    end
  end

  always_ff @(posedge clk) begin
    if (wrEn) begin
      pageQ[wrSlot] <= wrPage;
    end
  end

  for (genvar p = 0; p < PORTS; p++) begin : g_port
    logic [SLOTS-1:0]  match;
    logic [SLOT_W-1:0] enc;

    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
      assign match[s] = validQ[s] && (pageQ[s] == srchPage[p]);
    end

    // lowest matching slot wins
    always_comb begin
      enc = '0;
      for (int i = SLOTS - 1; i >= 0; i--) begin
        if (match[i]) enc = SLOT_W'(i);
      end
    end

    assign srchHit[p]  = |match;
    assign srchSlot[p] = enc;
  end

endmodule

// File: rtl/tag_ram.sv
module tag_ram #(
  parameter int DEPTH = 1024,
  parameter int DW    = 32,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          wrEn,
  input  logic [AW-1:0] wrAddr,
  input  logic [DW-1:0] wrMask,
  input  logic [DW-1:0] wrData,
  input  logic          rdEn,
  input  logic [AW-1:0] rdAddr,
  output logic [DW-1:0] rdData
);

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] merged;

  // bit-enable write: unmasked bits keep their stored value
  assign merged = (mem[wrAddr] & ~wrMask) | (wrData & wrMask);

  always_ff @(posedge clk) begin
    if (wrEn) begin
      mem[wrAddr] <= merged;
    end
    if (rdEn) begin
      rdData <= (wrEn && (wrAddr == rdAddr)) ? merged : mem[rdAddr];
    end
  end

endmodule

// File: rtl/tag_ctrl.sv
module tag_ctrl
  import page_tag_pkg::*;
#(
  parameter int             ID_W      = 4,
  parameter logic [ID_W-1:0] MODULE_ID = 4'd5
) (
  input  logic            cmdValid,
  input  logic [ID_W-1:0] cmdTarget,
  input  logic            cmdOp,
  input  logic            wbValid,
  input  logic            wbHit,
  output tagStrobeT       strobe
);

  logic  cmdMine;
  tagOpE op;

  assign op      = tagOpE'(cmdOp);
  assign cmdMine = cmdValid && (cmdTarget == MODULE_ID);

  always_comb begin
    strobe            = '0;
    strobe.camWr      = cmdMine && (op == OP_PAGE);
    strobe.ramFromCmd = cmdMine && (op == OP_MASK);
    // any accepted command owns the write side this cycle
    strobe.ramWr      = strobe.ramFromCmd || (!cmdMine && wbValid && wbHit);
  end

endmodule

// File: rtl/tag_datapath.sv
module tag_datapath
  import page_tag_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int PAGE_BITS  = 12,
  parameter int WORD_BYTES = 4,
  parameter int SLOTS      = 16,
  parameter int RAM_W      = 32,
  localparam int PAGE_NUM_W = ADDR_W - PAGE_BITS,
  localparam int WORD_LOG2  = $clog2(WORD_BYTES),
  localparam int WORD_OFF_W = PAGE_BITS - WORD_LOG2,
  localparam int LANE_W     = $clog2(RAM_W / 2),
  localparam int ROW_W      = WORD_OFF_W - LANE_W,
  localparam int SLOT_W     = $clog2(SLOTS),
  localparam int RAM_AW     = SLOT_W + ROW_W,
  localparam int RAM_DEPTH  = SLOTS << ROW_W
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  tagStrobeT             strobe,
  input  logic [SLOT_W-1:0]     cmdSlot,
  input  logic [PAGE_NUM_W-1:0] cmdPage,
  input  logic                  cmdEntryValid,
  input  logic [ROW_W-1:0]      cmdRow,
  input  logic [RAM_W-1:0]      cmdData,
  input  logic [ADDR_W-1:0]     wbAddr,
  input  logic                  wbTrusted,
  input  logic                  wbCritical,
  input  logic                  lookValid,
  input  logic [ADDR_W-1:0]     lookAddr,
  output logic                  wbHit,
  output logic                  respValid,
  output logic                  respTrusted,
  output logic                  respCritical,
  output logic                  respMiss
);

  logic [PAGE_NUM_W-1:0] lookPage, wbPage;
  logic [WORD_OFF_W-1:0] lookWord, wbWord;
  logic [ROW_W-1:0]      lookRow, wbRow;
  logic [LANE_W-1:0]     lookLane, wbLane;

  assign lookPage = lookAddr[ADDR_W-1:PAGE_BITS];
  assign lookWord = lookAddr[PAGE_BITS-1:WORD_LOG2];
  assign lookRow  = lookWord[WORD_OFF_W-1:LANE_W];
  assign lookLane = lookWord[LANE_W-1:0];

  assign wbPage = wbAddr[ADDR_W-1:PAGE_BITS];
  assign wbWord = wbAddr[PAGE_BITS-1:WORD_LOG2];
  assign wbRow  = wbWord[WORD_OFF_W-1:LANE_W];
  assign wbLane = wbWord[LANE_W-1:0];

  logic unusedByteBits;
  assign unusedByteBits = ^{lookAddr[WORD_LOG2-1:0], wbAddr[WORD_LOG2-1:0]};

  // CAM: port 0 serves lookups, port 1 serves writebacks
  logic [1:0]                  srchHit;
  logic [1:0][SLOT_W-1:0]      srchSlot;
  logic [1:0][PAGE_NUM_W-1:0]  srchPage;

  assign srchPage = {wbPage, lookPage};

  tag_cam #(
    .SLOTS      (SLOTS),
    .PAGE_NUM_W (PAGE_NUM_W),
    .PORTS      (2)
  ) u_cam (
    .clk      (clk),
    .rstN     (rstN),
    .wrEn     (strobe.camWr),
    .wrSlot   (cmdSlot),
    .wrPage   (cmdPage),
    .wrValid  (cmdEntryValid),
    .srchPage (srchPage),
    .srchHit  (srchHit),
    .srchSlot (srchSlot)
  );

  assign wbHit = srchHit[1];

  // write side mux
  logic [RAM_AW-1:0] wrAddr;
  logic [RAM_W-1:0]  wrMask, wrData;
  logic [LANE_W:0]   wbShift;

  assign wbShift = {wbLane, 1'b0};

  always_comb begin
    if (strobe.ramFromCmd) begin
      wrAddr = {cmdSlot, cmdRow};
      wrMask = '1;
      wrData = cmdData;
    end else begin
      wrAddr = {srchSlot[1], wbRow};
      wrMask = RAM_W'(2'b11) << wbShift;
      wrData = RAM_W'({wbCritical, wbTrusted}) << wbShift;
    end
  end

  logic [RAM_W-1:0] rdData;

  tag_ram #(
    .DEPTH (RAM_DEPTH),
    .DW    (RAM_W)
  ) u_ram (
    .clk    (clk),
    .wrEn   (strobe.ramWr),
    .wrAddr (wrAddr),
    .wrMask (wrMask),
    .wrData (wrData),
    .rdEn   (lookValid && srchHit[0]),
    .rdAddr ({srchSlot[0], lookRow}),
    .rdData (rdData)
  );

  // response stage
  logic              respValidQ, hitQ;
  logic [LANE_W-1:0] laneQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      respValidQ <= 1'b0;
      hitQ       <= 1'b0;
      laneQ      <= '0;
    end else begin
      respValidQ <= lookValid;
      hitQ       <= lookValid && srchHit[0];
      laneQ      <= lookLane;
    end
  end

  assign respValid    = respValidQ;
  assign respMiss     = respValidQ && !hitQ;
  assign respTrusted  = respValidQ && hitQ && rdData[{laneQ, 1'b0}];
  assign respCritical = respValidQ && hitQ && rdData[{laneQ, 1'b1}];

endmodule

// File: rtl/page_tag_store.sv
module page_tag_store
  import page_tag_pkg::*;
#(
  parameter int              ADDR_W     = 32,
  parameter int              PAGE_BITS  = 12,
  parameter int              WORD_BYTES = 4,
  parameter int              SLOTS      = 16,
  parameter int              RAM_W      = 32,
  parameter int              ID_W       = 4,
  parameter logic [ID_W-1:0] MODULE_ID  = 4'd5,
  localparam int PAGE_NUM_W = ADDR_W - PAGE_BITS,
  localparam int SLOT_W     = $clog2(SLOTS),
  localparam int ROW_W      = PAGE_BITS - $clog2(WORD_BYTES) - $clog2(RAM_W / 2)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  cmdValid,
  input  logic [ID_W-1:0]       cmdTarget,
  input  logic                  cmdOp,
  input  logic [SLOT_W-1:0]     cmdSlot,
  input  logic [PAGE_NUM_W-1:0] cmdPage,
  input  logic                  cmdEntryValid,
  input  logic [ROW_W-1:0]      cmdRow,
  input  logic [RAM_W-1:0]      cmdData,
  input  logic                  wbValid,
  input  logic [ADDR_W-1:0]     wbAddr,
  input  logic                  wbTrusted,
  input  logic                  wbCritical,
  input  logic                  lookValid,
  input  logic [ADDR_W-1:0]     lookAddr,
  output logic                  respValid,
  output logic                  respTrusted,
  output logic                  respCritical,
  output logic                  respMiss
);

  tagStrobeT strobe;
  logic      wbHit;

  tag_ctrl #(
    .ID_W      (ID_W),
    .MODULE_ID (MODULE_ID)
  ) u_ctrl (
    .cmdValid  (cmdValid),
    .cmdTarget (cmdTarget),
    .cmdOp     (cmdOp),
    .wbValid   (wbValid),
    .wbHit     (wbHit),
    .strobe    (strobe)
  );

  tag_datapath #(
    .ADDR_W     (ADDR_W),
    .PAGE_BITS  (PAGE_BITS),
    .WORD_BYTES (WORD_BYTES),
    .SLOTS      (SLOTS),
    .RAM_W      (RAM_W)
  ) u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .strobe        (strobe),
    .cmdSlot       (cmdSlot),
    .cmdPage       (cmdPage),
    .cmdEntryValid (cmdEntryValid),
    .cmdRow        (cmdRow),
    .cmdData       (cmdData),
    .wbAddr        (wbAddr),
    .wbTrusted     (wbTrusted),
    .wbCritical    (wbCritical),
    .lookValid     (lookValid),
    .lookAddr      (lookAddr),
    .wbHit         (wbHit),
    .respValid     (respValid),
    .respTrusted   (respTrusted),
    .respCritical  (respCritical),
    .respMiss      (respMiss)
  );

endmodule

// File: rtl/page_tag_store_chk.sv
module page_tag_store_chk #(
  parameter int              ID_W      = 4,
  parameter logic [ID_W-1:0] MODULE_ID = 4'd5
) (
  input logic            clk,
  input logic            rstN,
  input logic            cmdValid,
  input logic [ID_W-1:0] cmdTarget,
  input logic            cmdOp,
  input logic            lookValid,
  input logic            respValid,
  input logic            respTrusted,
  input logic            respCritical,
  input logic            respMiss
);

  // set once any page command for this module has been accepted
  logic pageSeen;
  always_ff @(posedge clk) begin
    if (!rstN) pageSeen <= 1'b0;
    else if (cmdValid && cmdTarget == MODULE_ID && !cmdOp) pageSeen <= 1'b1;
  end

  p_resp_follows_r2: assert property (@(posedge clk) disable iff (!rstN)
    lookValid |=> respValid);

  p_no_stray_resp_r2: assert property (@(posedge clk) disable iff (!rstN)
    !lookValid |=> !respValid);

  p_quiet_idle_r2: assert property (@(posedge clk) disable iff (!rstN)
    !respValid |-> (!respTrusted && !respCritical && !respMiss));

  p_miss_clean_r4: assert property (@(posedge clk) disable iff (!rstN)
    respMiss |-> (!respTrusted && !respCritical));

  p_empty_misses_r1: assert property (@(posedge clk) disable iff (!rstN)
    (lookValid && !pageSeen) |=> respMiss);

endmodule

bind page_tag_store page_tag_store_chk #(
  .ID_W      (ID_W),
  .MODULE_ID (MODULE_ID)
) u_chk (.*);

// File: tb/tb_page_tag_store.sv
module tb_page_tag_store;

  localparam logic [3:0] ID = 4'd5;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdValid = 1'b0;
  logic [3:0]  cmdTarget = '0;
  logic        cmdOp = 1'b0;
  logic [3:0]  cmdSlot = '0;
  logic [19:0] cmdPage = '0;
  logic        cmdEntryValid = 1'b0;
  logic [5:0]  cmdRow = '0;
  logic [31:0] cmdData = '0;
  logic        wbValid = 1'b0;
  logic [31:0] wbAddr = '0;
  logic        wbTrusted = 1'b0;
  logic        wbCritical = 1'b0;
  logic        lookValid = 1'b0;
  logic [31:0] lookAddr = '0;
  logic        respValid, respTrusted, respCritical, respMiss;

  always #4 clk = ~clk;

  page_tag_store dut (.*);

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // bench model
  logic [31:0] mdl [16][64];
  logic [19:0] mdlPage [16];
  logic        mdlValid [16];

  function automatic logic [31:0] pat(input int s, input int r);
    return (32'(s) * 32'h9E3779B1) ^ (32'(r) * 32'h7F4A7C15) ^ 32'h3C96A55A;
  endfunction

  function automatic logic [2:0] expLook(input logic [31:0] a);
    logic [2:0] e;
    e = 3'b100; // {miss, trusted, critical}
    for (int s = 15; s >= 0; s--) begin
      if (mdlValid[s] && mdlPage[s] == a[31:12])
        e = {1'b0, mdl[s][a[11:6]][{a[5:2], 1'b0}], mdl[s][a[11:6]][{a[5:2], 1'b1}]};
    end
    return e;
  endfunction

  function automatic logic [31:0] mkAddr(input logic [19:0] pg, input int w);
    return {pg, 10'(w), 2'(w)};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic sampleResp(input string req, input logic [2:0] e, input logic [31:0] a);
    logic [3:0] act;
    act = {respValid, respMiss, respTrusted, respCritical};
    chk(act == {1'b1, e}, req, $sformatf("lookup %08h", a), 32'(act), 32'({1'b1, e}));
  endtask

  task automatic lookCheck(input logic [31:0] a, input string req);
    logic [2:0] e;
    e = expLook(a);
    lookValid = 1'b1;
    lookAddr  = a;
    @(negedge clk);
    lookValid = 1'b0;
    sampleResp(req, e, a);
  endtask

  task automatic sendPage(input logic [3:0] tgt, input int s, input logic [19:0] pg, input bit v);
    cmdValid = 1'b1; cmdTarget = tgt; cmdOp = 1'b0;
    cmdSlot = 4'(s); cmdPage = pg; cmdEntryValid = v;
    @(negedge clk);
    cmdValid = 1'b0;
    if (tgt == ID) begin mdlPage[s] = pg; mdlValid[s] = v; end
  endtask

  task automatic sendMask(input logic [3:0] tgt, input int s, input int r, input logic [31:0] d);
    cmdValid = 1'b1; cmdTarget = tgt; cmdOp = 1'b1;
    cmdSlot = 4'(s); cmdRow = 6'(r); cmdData = d;
    @(negedge clk);
    cmdValid = 1'b0;
    if (tgt == ID) mdl[s][r] = d;
  endtask

  function automatic void mdlWb(input logic [31:0] a, input bit t, input bit c);
    for (int s = 15; s >= 0; s--) begin
      if (mdlValid[s] && mdlPage[s] == a[31:12]) begin
        mdl[s][a[11:6]][{a[5:2], 1'b0}] = t;
        mdl[s][a[11:6]][{a[5:2], 1'b1}] = c;
        return;
      end
    end
  endfunction

  task automatic doWb(input logic [31:0] a, input bit t, input bit c);
    wbValid = 1'b1; wbAddr = a; wbTrusted = t; wbCritical = c;
    @(negedge clk);
    wbValid = 1'b0;
    mdlWb(a, t, c);
  endtask

  task automatic rowCheck(input logic [19:0] pg, input int r, input string req);
    for (int k = 0; k < 16; k++) lookCheck(mkAddr(pg, r * 16 + k), req);
  endtask

  task automatic sweep(input string req);
    for (int s = 0; s < 16; s++)
      if (mdlValid[s])
        for (int w = 0; w < 1024; w++) lookCheck(mkAddr(mdlPage[s], w), req);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R2 watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [2:0]  e;
    logic [31:0] a;
    logic [19:0] q;
    for (int s = 0; s < 16; s++) begin
      mdlValid[s] = 1'b0; mdlPage[s] = '0;
      for (int r = 0; r < 64; r++) mdl[s][r] = '0;
    end

    repeat (3) @(negedge clk);
    chk({respValid, respMiss, respTrusted, respCritical} == 4'b0, "R2", "outputs in reset",
        32'({respValid, respMiss, respTrusted, respCritical}), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk({respValid, respMiss, respTrusted, respCritical} == 4'b0, "R1", "outputs after reset",
        32'({respValid, respMiss, respTrusted, respCritical}), 0);
    lookCheck(32'h0000_1000, "R1");
    lookCheck(32'h1000_0004, "R1");

    // R7: foreign page command
    sendPage(ID ^ 4'd1, 0, 20'h00ABC, 1'b1);
    lookCheck(32'h00AB_C000, "R7");

    // configuration
    for (int s = 0; s < 16; s++) sendPage(ID, s, 20'h10000 + 20'(s * 'h111), 1'b1);
    for (int s = 0; s < 16; s++)
      for (int r = 0; r < 64; r++) sendMask(ID, s, r, pat(s, r));

    // R7: foreign mask command
    sendMask(4'd6, 3, 7, 32'hFFFF_FFFF);
    rowCheck(mdlPage[3], 7, "R7");

    sweep("R3 R6");

    // R4: non-resident pages
    lookCheck(32'h0000_0000, "R4");
    lookCheck(32'hFFFF_FFFC, "R4");
    lookCheck(mkAddr(mdlPage[0] + 20'd1, 5), "R4");

    // R8: single-word writebacks
    a = mkAddr(mdlPage[5], 37);
    e = expLook(a);
    doWb(a, ~e[1], ~e[0]);
    rowCheck(mdlPage[5], 2, "R8");
    doWb(mkAddr(mdlPage[1], 0), 1'b1, 1'b0);
    doWb(mkAddr(mdlPage[1], 15), 1'b0, 1'b1);
    doWb(mkAddr(mdlPage[12], 1023), 1'b1, 1'b1);
    rowCheck(mdlPage[1], 0, "R8");
    rowCheck(mdlPage[12], 63, "R8");
    doWb(32'h00AB_C010, 1'b1, 1'b1);
    lookCheck(32'h00AB_C010, "R8");

    // R9: mask command and writeback together
    a = mkAddr(mdlPage[3], 0);
    e = expLook(a);
    cmdValid = 1'b1; cmdTarget = ID; cmdOp = 1'b1; cmdSlot = 4'd2; cmdRow = 6'd5;
    cmdData = 32'hA5A5_0FF0;
    wbValid = 1'b1; wbAddr = a; wbTrusted = ~e[1]; wbCritical = ~e[0];
    @(negedge clk);
    cmdValid = 1'b0; wbValid = 1'b0;
    mdl[2][5] = 32'hA5A5_0FF0;
    rowCheck(mdlPage[2], 5, "R9");
    rowCheck(mdlPage[3], 0, "R9");
    // page command and writeback together
    a = mkAddr(mdlPage[6], 3);
    e = expLook(a);
    cmdValid = 1'b1; cmdTarget = ID; cmdOp = 1'b0; cmdSlot = 4'd6; cmdPage = mdlPage[6];
    cmdEntryValid = 1'b1;
    wbValid = 1'b1; wbAddr = a; wbTrusted = ~e[1]; wbCritical = ~e[0];
    @(negedge clk);
    cmdValid = 1'b0; wbValid = 1'b0;
    lookCheck(a, "R9");

    // R10: writeback and lookup to the same word
    a = mkAddr(mdlPage[7], 50);
    e = expLook(a);
    wbValid = 1'b1; wbAddr = a; wbTrusted = ~e[1]; wbCritical = ~e[0];
    lookValid = 1'b1; lookAddr = a;
    mdlWb(a, ~e[1], ~e[0]);
    e = expLook(a);
    @(negedge clk);
    wbValid = 1'b0; lookValid = 1'b0;
    sampleResp("R10", e, a);
    // mask command and lookup to the same row
    a = mkAddr(mdlPage[8], 147);
    cmdValid = 1'b1; cmdTarget = ID; cmdOp = 1'b1; cmdSlot = 4'd8; cmdRow = 6'd9;
    cmdData = ~mdl[8][9];
    lookValid = 1'b1; lookAddr = a;
    mdl[8][9] = ~mdl[8][9];
    e = expLook(a);
    @(negedge clk);
    cmdValid = 1'b0; lookValid = 1'b0;
    sampleResp("R10", e, a);

    // R5: page replacement timing
    q = 20'h55555;
    a = mkAddr(q, 200);
    e = expLook(a);
    cmdValid = 1'b1; cmdTarget = ID; cmdOp = 1'b0; cmdSlot = 4'd4; cmdPage = q;
    cmdEntryValid = 1'b1;
    lookValid = 1'b1; lookAddr = a;
    @(negedge clk);
    cmdValid = 1'b0; lookValid = 1'b0;
    sampleResp("R5", e, a);
    a = mkAddr(mdlPage[4], 200);
    mdlPage[4] = q;
    lookCheck(mkAddr(q, 200), "R5");
    lookCheck(mkAddr(q, 1), "R5");
    lookCheck(a, "R5");
    sendPage(ID, 4, q, 1'b0);
    lookCheck(mkAddr(q, 200), "R5");
    sendPage(ID, 4, q, 1'b1);
    lookCheck(mkAddr(q, 201), "R5");

    // R11: duplicate page numbers
    sendPage(ID, 9, mdlPage[2], 1'b1);
    for (int w = 0; w < 32; w++) lookCheck(mkAddr(mdlPage[2], w), "R11");
    sendPage(ID, 2, mdlPage[2], 1'b0);
    for (int w = 0; w < 32; w++) lookCheck(mkAddr(mdlPage[9], w), "R11");

    sweep("R8");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule